// File: doc/BRIEF.md
# Reset Cause Register

This block keeps a record of why the chip last came out of reset. It watches four kinds of event: the power-on reset, the external reset pin, a watchdog timeout, and brown-out of the supply. For each one it holds a sticky flag. Each flag has its own rules for which other events clear it. After boot, software reads the flags to learn the cause of the restart. It clears a flag by writing a one to that bit.

The power-on reset is the block's own active-low asynchronous reset `rst_ni`. While it is low, the flags are forced at once to "power-on only". Every other event input passes through a two-stage synchronizer before it reaches the flag logic.

The supply monitor is modelled as two digital levels: below the brown-out threshold, and below the power-on level. A brown-out flag is recorded when the supply recovers from below the threshold. That covers both a dip that comes back and a full ramp-up from power-on. A collapse all the way to the power-on level erases the brown-out flag.

Top module: `reset_cause_reg`

## Requirements
- R1: While `rst_ni` is low, `rd_data_o` reads 0x01 without waiting for a clock edge: bit 0 (power-on) is set and bits 1, 2 and 3 are cleared.
- R2: Bit 0 is not cleared by external, watchdog or brown-out events. Only a write with bit 0 at one clears it.
- R3: A high level on `ext_rst_i` sets bit 1. If `ext_rst_i` is still high when `rst_ni` is released, bit 1 becomes set afterwards.
- R4: Bit 1 is not changed by watchdog or brown-out events.
- R5: Bit 2 is set by a pulse on `wdt_timeout_i` only while `wdt_rst_en_i` is 1. With `wdt_rst_en_i` at 0, a timeout leaves the register unchanged.
- R6: Bit 2 is cleared whenever `ext_rst_i` or `bod_low_i` is high. Such a clear takes priority over a simultaneous watchdog set.
- R7: Bit 3 is set when `bod_low_i` falls after having been high. This includes the first fall after power-on reset, because the supply is assumed low while `rst_ni` is low.
- R8: Bit 3 is cleared while `bod_por_lvl_i` is high. External and watchdog events do not change bit 3.
- R9: When `wr_en_i` is high, each of bits 3:0 whose `wr_data_i` bit is 1 is cleared, and a 0 leaves the bit alone. Bits 7:4 always read 0, and writes to them have no effect.
- R10: If a hardware set and a write-one-clear hit the same flag in the same cycle, the flag stays set.
- R11: An event input that changes between clock edges shows in `rd_data_o` after the third following rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_i | input | 1 | External reset pin level, active high |
| wdt_timeout_i | input | 1 | Watchdog timeout event |
| wdt_rst_en_i | input | 1 | Watchdog reset-enable setting |
| bod_low_i | input | 1 | Supply below brown-out threshold |
| bod_por_lvl_i | input | 1 | Supply below power-on level |
| wr_en_i | input | 1 | Write strobe for write-one-to-clear |
| wr_data_i | input | REG_W | Write data, a one clears the matching flag |
| rd_data_o | output | REG_W | Flag readout, bits 7:4 read 0 |

## Verification
The hardest state to reach is the brown-out flag after a supply collapse. The bench first builds a register with every flag set. It then raises the threshold and power-on-level inputs together, which must clear both the brown-out and watchdog flags. Releasing both inputs in the same cycle must then record a fresh brown-out. A second hard case is a write-one-clear that lands while the external pin is held high. The bench holds the pin for several cycles so that the set is active exactly when the write strobe arrives.

// File: rtl/rsid_pkg.sv
package rsid_pkg;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned SRC_POR = 0;
  localparam int unsigned SRC_EXT = 1;
  localparam int unsigned SRC_WDT = 2;
  localparam int unsigned SRC_BOD = 3;

  // synchronized event lanes
  localparam int unsigned EV_EXT  = 0;
  localparam int unsigned EV_WTO  = 1;
  localparam int unsigned EV_WEN  = 2;
  localparam int unsigned EV_LOW  = 3;
  localparam int unsigned EV_PLV  = 4;
  localparam int unsigned NUM_EV  = 5;
  // supply assumed below threshold during power-on reset
  localparam logic [NUM_EV-1:0] EV_RST_VAL = 5'b01000;
endpackage

// File: rtl/rsid_sync.sv
module rsid_sync #(
  parameter int unsigned WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg1_q, stg2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg1_q <= RST_VAL;
      stg2_q <= RST_VAL;
    end else begin
      stg1_q <= d_i;
      stg2_q <= stg1_q;
    end
  end

  assign q_o = stg2_q;
endmodule

// File: rtl/rsid_bod_track.sv
module rsid_bod_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_i,
  input  logic por_lvl_i,
  output logic set_o,
  output logic clr_o
);
  logic armed_q, armed_d;

  // armed while supply has been low since the last recovery
  always_comb begin
    armed_d = armed_q;
    if (low_i)      armed_d = 1'b1;
    else if (set_o) armed_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b1;
    else         armed_q <= armed_d;
  end

  assign set_o = armed_q & ~low_i;
  assign clr_o = por_lvl_i;

  AST_BOD_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o |=> !set_o); // R7
endmodule

// File: rtl/rsid_flag.sv
module rsid_flag #(
  parameter logic POR_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic w1c_i,
  output logic q_o
);
  logic q_d;

  // source clear > source set > software clear
  always_comb begin
    q_d = q_o;
    if (clr_i)      q_d = 1'b0;
    else if (set_i) q_d = 1'b1;
    else if (w1c_i) q_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= POR_VAL;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import rsid_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_rst_i,
  input  logic             wdt_timeout_i,
  input  logic             wdt_rst_en_i,
  input  logic             bod_low_i,
  input  logic             bod_por_lvl_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o
);
  localparam int unsigned PAD_W = REG_W - NUM_SRC;

  logic [NUM_EV-1:0]  ev_raw, ev_s;
  logic [NUM_SRC-1:0] flag_set, flag_clr, flag_w1c, flag_q;
  logic               bod_set, bod_clr;
  logic               unused_wr_hi;

  assign ev_raw[EV_EXT] = ext_rst_i;
  assign ev_raw[EV_WTO] = wdt_timeout_i;
  assign ev_raw[EV_WEN] = wdt_rst_en_i;
  assign ev_raw[EV_LOW] = bod_low_i;
  assign ev_raw[EV_PLV] = bod_por_lvl_i;

  rsid_sync #(.WIDTH(NUM_EV), .RST_VAL(EV_RST_VAL)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ev_raw),
    .q_o   (ev_s)
  );

  rsid_bod_track u_bod (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .low_i    (ev_s[EV_LOW]),
    .por_lvl_i(ev_s[EV_PLV]),
    .set_o    (bod_set),
    .clr_o    (bod_clr)
  );

  always_comb begin
    flag_set          = '0;
    flag_clr          = '0;
    flag_set[SRC_EXT] = ev_s[EV_EXT];
    flag_set[SRC_WDT] = ev_s[EV_WTO] & ev_s[EV_WEN];
    flag_clr[SRC_WDT] = ev_s[EV_EXT] | ev_s[EV_LOW];
    flag_set[SRC_BOD] = bod_set;
    flag_clr[SRC_BOD] = bod_clr;
  end

  assign flag_w1c = wr_data_i[NUM_SRC-1:0] & {NUM_SRC{wr_en_i}};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    rsid_flag #(.POR_VAL(i == SRC_POR)) u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (flag_set[i]),
      .clr_i (flag_clr[i]),
      .w1c_i (flag_w1c[i]),
      .q_o   (flag_q[i])
    );
  end

  assign unused_wr_hi = ^wr_data_i[REG_W-1:NUM_SRC];
  assign rd_data_o    = {{PAD_W{1'b0}}, flag_q};

  AST_POR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q[SRC_POR]) |-> $past(wr_en_i && wr_data_i[SRC_POR])); // R2
  AST_EXT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q[SRC_EXT]) |-> $past(wr_en_i && wr_data_i[SRC_EXT])); // R4
  AST_WDT_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_s[EV_EXT] || ev_s[EV_LOW]) |=> !flag_q[SRC_WDT]); // R6
  AST_BOD_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_s[EV_PLV] |=> !flag_q[SRC_BOD]); // R8
  AST_SET_BEATS_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[SRC_EXT] && ev_s[EV_EXT]) |=> flag_q[SRC_EXT]); // R10
  AST_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(rd_data_o[REG_W-1:NUM_SRC])); // R9
endmodule

// File: tb/sim_reset_cause_reg.sv
`timescale 1ns/1ps
module sim_reset_cause_reg;
  logic       clk = 1'b0;
  logic       rst_ni, ext_rst, wdt_to, wdt_en, bod_low, bod_plv, wr_en;
  logic [7:0] wr_data, rd_data;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 1'b0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  reset_cause_reg u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ext_rst_i(ext_rst), .wdt_timeout_i(wdt_to),
    .wdt_rst_en_i(wdt_en), .bod_low_i(bod_low), .bod_por_lvl_i(bod_plv),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_rd(input logic [7:0] v, input string tag);
    exp_t e;
    e.val = v;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic w1c(input logic [7:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    tick(1);
    wr_en   = 1'b0;
    wr_data = 8'h00;
  endtask

  // monitor: compare one queued item per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (rd_data !== e.val) begin
          n_bad++;
          $display("FAIL %s: got 0x%02h expected 0x%02h", e.tag, rd_data, e.val);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; ext_rst = 1'b0; wdt_to = 1'b0; wdt_en = 1'b0;
    bod_low = 1'b1; bod_plv = 1'b1; wr_en = 1'b0; wr_data = 8'h00;
    tick(2);
    expect_rd(8'h01, "R1 reset state");
    tick(1);
    // power-up ramp
    rst_ni = 1'b1; bod_plv = 1'b0;
    tick(4);
    expect_rd(8'h01, "R7 no brown-out flag while still low");
    bod_low = 1'b0;
    tick(2);
    expect_rd(8'h01, "R11 not yet after two edges");
    tick(1);
    expect_rd(8'h09, "R7 ramp-up recorded");
    tick(1);
    w1c(8'h08);
    expect_rd(8'h01, "R9 write one clears bod");
    tick(1);
    w1c(8'h00);
    expect_rd(8'h01, "R9 write zero no effect");
    tick(1);
    w1c(8'hF0);
    expect_rd(8'h01, "R9 reserved writes ignored");
    tick(1);
    // external reset latency
    ext_rst = 1'b1;
    tick(2);
    expect_rd(8'h01, "R11 ext not after two edges");
    tick(1);
    expect_rd(8'h03, "R3 ext sets bit1");
    ext_rst = 1'b0;
    tick(4);
    expect_rd(8'h03, "R3 ext flag sticky");
    // watchdog disabled / enabled
    wdt_to = 1'b1; tick(1); wdt_to = 1'b0;
    tick(4);
    expect_rd(8'h03, "R5 timeout without enable ignored");
    wdt_en = 1'b1; tick(3);
    wdt_to = 1'b1; tick(1); wdt_to = 1'b0;
    tick(4);
    expect_rd(8'h07, "R5 R4 wdt set, ext kept");
    ext_rst = 1'b1; tick(4); ext_rst = 1'b0; tick(3);
    expect_rd(8'h03, "R6 ext clears wdt");
    tick(1);
    w1c(8'h02);
    expect_rd(8'h01, "R9 clear ext");
    wdt_to = 1'b1; tick(1); wdt_to = 1'b0;
    tick(4);
    expect_rd(8'h05, "R5 wdt set again");
    bod_low = 1'b1; tick(4);
    expect_rd(8'h01, "R6 R2 brown-out clears wdt keeps por");
    bod_low = 1'b0; tick(4);
    expect_rd(8'h09, "R7 dip and recover");
    ext_rst = 1'b1; tick(4); ext_rst = 1'b0; tick(3);
    expect_rd(8'h0B, "R8 ext leaves bod");
    tick(1);
    wdt_to = 1'b1; tick(1); wdt_to = 1'b0;
    tick(4);
    expect_rd(8'h0F, "R8 R4 wdt leaves bod and ext");
    // collapse to power-on level
    bod_low = 1'b1; bod_plv = 1'b1; tick(4);
    expect_rd(8'h03, "R8 collapse clears bod and wdt");
    tick(1);
    bod_low = 1'b0; bod_plv = 1'b0; tick(4);
    expect_rd(8'h0B, "R7 recovery after collapse");
    tick(1);
    // set versus write-one-clear
    ext_rst = 1'b1; tick(4);
    w1c(8'h02);
    expect_rd(8'h0B, "R10 set beats w1c");
    ext_rst = 1'b0; tick(4);
    w1c(8'h02);
    expect_rd(8'h09, "R9 ext cleared after release");
    tick(1);
    // power-on reset with external pin held
    bod_low = 1'b1; bod_plv = 1'b1; ext_rst = 1'b1;
    #1 rst_ni = 1'b0;
    tick(1);
    expect_rd(8'h01, "R1 asynchronous por");
    tick(2);
    rst_ni = 1'b1; bod_plv = 1'b0;
    tick(2);
    expect_rd(8'h01, "R11 ext pending after por");
    tick(1);
    expect_rd(8'h03, "R3 ext held through por");
    tick(1);
    bod_low = 1'b0; tick(4);
    expect_rd(8'h0B, "R7 bod after por ramp");
    tick(1);
    ext_rst = 1'b0; tick(4);
    w1c(8'hFF);
    expect_rd(8'h00, "R2 R9 por cleared by write only");
    tick(3);
    wait (exp_q.size() == 0);
    tick(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule